// File: doc/BRIEF.md
# Sampling Converter Conversion Handshake Controller

This block is the digital control side of a sampling 12-bit analog-to-digital converter. Two active-low controls, a chip select (`cs_n`) and a read/convert line (`rc_n`), are brought through a two-stage synchronizer. A convert request exists only while both synchronized controls are low, whichever of them fell last. Once the request has lasted a programmable number of clock cycles, the block captures the converter's input word, which models the sample/hold entering hold. It then pulls `busy_n` low for a fixed number of cycles, and at the end it loads the captured word into the result register.

The result is read through an 8-bit parallel port. `byte_sel` picks the upper eight result bits or the lower four bits padded with zeros. The port is enabled only while `cs_n` is low. A separate output enable stands in for the high-impedance state, so no internal tristates are needed.

After each conversion an acquisition counter runs. If the next conversion starts before the counter has expired, `acq_short` is raised. If both controls are still low when `busy_n` returns high, a new conversion starts on the next cycle without qualifying the low time again. Such an immediate restart always raises `acq_short`.

The controller is a four-state machine:
- `S_IDLE`: waiting for a request.
- `S_QUAL`: counting the request's low time.
- `S_CONV`: converting, with `busy_n` low.
- `S_DONE`: one cycle with `busy_n` high while the result is presented.

Its transitions are:
- IDLE→QUAL when a request appears.
- QUAL→IDLE when the request drops early.
- QUAL→CONV when the low time is met.
- CONV→DONE when the conversion count ends.
- DONE→CONV when the request is still present (restart).
- DONE→IDLE otherwise.

Top module: `adc_conv_ctrl`

## Requirements
- R1: A conversion is requested only while `cs_n` and `rc_n` are both low; either one may be the last to fall, and one line low alone never starts a conversion.
- R2: With parameter `LOW_CYC` (default 4), `busy_n` falls at the (`LOW_CYC`+2)th rising edge after both controls are low. A request lasting fewer than `LOW_CYC` synchronized cycles starts nothing.
- R3: `busy_n` stays low for exactly `CONV_CYC` cycles, and the new result is visible in the same cycle that `busy_n` returns high.
- R4: Changes of `cs_n`/`rc_n` while `busy_n` is low neither lengthen the conversion nor leave a pending start once it ends.
- R5: If the request is still present in the cycle `busy_n` returns high, a new conversion starts on the next edge, so `busy_n` is high for exactly one cycle.
- R6: `acq_short` is 0 after reset. At each conversion start it becomes 1 if that start falls within `ACQ_CYC` cycles of the previous conversion's end, and 0 otherwise. It holds that value until the next start. An immediate restart (R5) always sets it.
- R7: With `byte_sel`=0 and the port enabled, `pdata[7:0]` equals result bits 11 down to 4, with result bit 11 on `pdata[7]`.
- R8: With `byte_sel`=1 and the port enabled, `pdata[7:4]` equals result bits 3 down to 0 and `pdata[3:0]` is 0000.
- R9: `pdata_oe` is 1 exactly while `cs_n` is low, following it combinationally. While `pdata_oe` is 0, `pdata` is all zeros.
- R10: The result equals `conv_data` as sampled on the edge where the conversion starts, and it changes only when `busy_n` rises.
- R11: After reset, `busy_n` is 1, `acq_short` is 0 and the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rc_n | input | 1 | Read (high) / convert (low) control |
| byte_sel | input | 1 | 0: upper result byte, 1: lower nibble padded |
| conv_data | input | 12 | Converter word, sampled at conversion start |
| busy_n | output | 1 | Low while a conversion is running |
| pdata | output | 8 | Parallel read data |
| pdata_oe | output | 1 | Read port drive enable (low means high impedance) |
| acq_short | output | 1 | Last conversion started before acquisition finished |

## Verification
`busy_n` is due low at the (`LOW_CYC`+2)th edge after both controls are low. The bench checks it at the falling edge just before and just after that rising edge. `busy_n` is then low for `CONV_CYC` samples. The result and `acq_short` are due in the same cycle that `busy_n` rises; the scoreboard monitor samples one time unit after each rising edge and compares at that rise. In a restart, `busy_n` is due low again one cycle later. The read port is combinational from `cs_n` and `byte_sel`, so it is checked one time unit after those inputs change.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_QUAL = 2'd1,
        S_CONV = 2'd2,
        S_DONE = 2'd3
    } conv_state_e;
endpackage

// File: rtl/adc_sync.sv
module adc_sync #(
    parameter int W       = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1[i] <= RST_VAL;
                stage2[i] <= RST_VAL;
            end else begin
                stage1[i] <= din[i];
                stage2[i] <= stage1[i];
            end
        end
    end

    assign dout = stage2;
endmodule

// File: rtl/adc_conv_fsm.sv
module adc_conv_fsm
    import adc_ctrl_pkg::*;
#(
    parameter int LOW_CYC  = 4,
    parameter int CONV_CYC = 16,
    parameter int ACQ_CYC  = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic start,
    output logic done,
    output logic busy_n,
    output logic acq_short
);
    localparam int LW = $clog2(LOW_CYC + 1);
    localparam int CW = $clog2(CONV_CYC + 1);
    localparam int AW = $clog2(ACQ_CYC + 1);

    conv_state_e   state, nxt;
    logic [LW-1:0] low_cnt;
    logic [CW-1:0] conv_cnt;
    logic [AW-1:0] acq_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (req) nxt = S_QUAL;
            S_QUAL: begin
                if (!req)                               nxt = S_IDLE;
                else if (low_cnt == LW'(LOW_CYC - 1))   nxt = S_CONV;
            end
            S_CONV: if (conv_cnt == CW'(CONV_CYC - 1))  nxt = S_DONE;
            S_DONE: nxt = req ? S_CONV : S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_n = (state != S_CONV);
        start  = (nxt == S_CONV) && (state != S_CONV);
        done   = (state == S_CONV) && (nxt == S_DONE);
    end

    // counters and acquisition flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt   <= '0;
            conv_cnt  <= '0;
            acq_cnt   <= '0;
            acq_short <= 1'b0;
        end else begin
            if (state == S_IDLE)      low_cnt <= req ? LW'(1) : '0;
            else if (state == S_QUAL) low_cnt <= req ? low_cnt + 1'b1 : '0;
            else                      low_cnt <= '0;

            conv_cnt <= (state == S_CONV) ? conv_cnt + 1'b1 : '0;

            if (done)                 acq_cnt <= AW'(ACQ_CYC);
            else if (acq_cnt != '0)   acq_cnt <= acq_cnt - 1'b1;

            if (start) acq_short <= (acq_cnt != '0);
        end
    end

    // checker: length of the busy window
    logic [CW-1:0] busy_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       busy_len <= '0;
        else if (!busy_n) busy_len <= busy_len + 1'b1;
        else              busy_len <= '0;
    end

    a_r1_start_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_n) |-> $past(req));
    a_r3_conv_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) |-> busy_len == CW'(CONV_CYC));
    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) && req |=> !busy_n);
    a_r6_acq_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_n) && ($past(acq_cnt) != '0) |-> acq_short);
endmodule

// File: rtl/adc_rd_port.sv
module adc_rd_port #(
    parameter int DW = 12,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_en,
    input  logic          load_en,
    input  logic [DW-1:0] din,
    input  logic          byte_sel,
    input  logic          cs_n,
    output logic [DW-1:0] result,
    output logic [BW-1:0] pdata,
    output logic          pdata_oe
);
    localparam int LOW_BITS = DW - BW;
    localparam int PAD      = 2 * BW - DW;

    logic [DW-1:0] samp_q;
    logic [DW-1:0] res_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q <= '0;
            res_q  <= '0;
        end else begin
            if (sample_en) samp_q <= din;
            if (load_en)   res_q  <= samp_q;
        end
    end

    always_comb begin
        pdata_oe = !cs_n;
        if (!pdata_oe)     pdata = '0;
        else if (byte_sel) pdata = {res_q[LOW_BITS-1:0], {PAD{1'b0}}};
        else               pdata = res_q[DW-1 -: BW];
    end

    assign result = res_q;

    a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pdata_oe |-> pdata == '0);
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl #(
    parameter int DW       = 12,
    parameter int BW       = 8,
    parameter int LOW_CYC  = 4,
    parameter int CONV_CYC = 16,
    parameter int ACQ_CYC  = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rc_n,
    input  logic          byte_sel,
    input  logic [DW-1:0] conv_data,
    output logic          busy_n,
    output logic [BW-1:0] pdata,
    output logic          pdata_oe,
    output logic          acq_short
);
    logic [1:0]    ctl_s;
    logic          req;
    logic          start;
    logic          done;
    logic [DW-1:0] result;

    adc_sync #(.W(2), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_n, rc_n}),
        .dout (ctl_s)
    );

    assign req = !ctl_s[1] && !ctl_s[0];

    adc_conv_fsm #(
        .LOW_CYC (LOW_CYC),
        .CONV_CYC(CONV_CYC),
        .ACQ_CYC (ACQ_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .start    (start),
        .done     (done),
        .busy_n   (busy_n),
        .acq_short(acq_short)
    );

    adc_rd_port #(.DW(DW), .BW(BW)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_en(start),
        .load_en  (done),
        .din      (conv_data),
        .byte_sel (byte_sel),
        .cs_n     (cs_n),
        .result   (result),
        .pdata    (pdata),
        .pdata_oe (pdata_oe)
    );

    a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(busy_n) |-> $stable(result));
endmodule

// File: tb/adc_conv_ctrl_tb.sv
module adc_conv_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LOW  = 4;
    localparam int CONV = 16;
    localparam int ACQ  = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        rc_n = 1'b1;
    logic        byte_sel = 1'b0;
    logic [11:0] conv_data = '0;
    logic        busy_n;
    logic [7:0]  pdata;
    logic        pdata_oe;
    logic        acq_short;

    int checks = 0;
    int failures = 0;
    logic [12:0] exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_conv_ctrl #(.LOW_CYC(LOW), .CONV_CYC(CONV), .ACQ_CYC(ACQ)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rc_n(rc_n),
        .byte_sel(byte_sel), .conv_data(conv_data), .busy_n(busy_n),
        .pdata(pdata), .pdata_oe(pdata_oe), .acq_short(acq_short)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: request a conversion, push the expected item
    task automatic start_conv(input logic [11:0] d, input bit exp_acq);
        conv_data = d;
        cs_n = 1'b0;
        rc_n = 1'b0;
        exp_q.push_back({exp_acq, d});
        repeat (LOW + 1) @(negedge clk);
        chk(busy_n == 1'b1, "R2 busy before low time met", int'(busy_n), 1);
        @(negedge clk);
        chk(busy_n == 1'b0, "R2 busy after low time met", int'(busy_n), 0);
        rc_n = 1'b1;
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic expect_quiet(input int n, input string tag);
        int lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!busy_n) lows++;
        end
        chk(lows == 0, tag, lows, 0);
    endtask

    // monitor: compare at each rise of busy_n
    initial begin
        int  lowrun = 0;
        bit  prev = 1'b1;
        logic [12:0] e;
        forever begin
            @(posedge clk);
            #1;
            if (!rst_n) begin
                lowrun = 0;
                prev = 1'b1;
            end else begin
                if (!busy_n) lowrun++;
                else if (!prev) begin
                    chk(lowrun == CONV, "R3 busy low length", lowrun, CONV);
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R4 unexpected conversion", 1, 0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(pdata == e[11:4], "R7 R10 upper byte at busy rise",
                            int'(pdata), int'(e[11:4]));
                        chk(acq_short == e[12], "R6 acquisition flag",
                            int'(acq_short), int'(e[12]));
                    end
                    lowrun = 0;
                end
                prev = busy_n;
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_n == 1'b1, "R11 busy after reset", int'(busy_n), 1);
        chk(acq_short == 1'b0, "R11 acq flag after reset", int'(acq_short), 0);
        cs_n = 1'b0;
        #1;
        chk(pdata == 8'h00, "R11 result zero after reset", int'(pdata), 0);
        cs_n = 1'b1;
        repeat (ACQ + 5) @(negedge clk);

        // R1: read/convert low alone starts nothing, cs falling last starts
        rc_n = 1'b0;
        expect_quiet(10, "R1 rc_n low alone");
        start_conv(12'hA5C, 1'b0);
        wait_idle();

        // R8 low nibble, R9 enable follows cs_n
        byte_sel = 1'b1;
        #1;
        chk(pdata == 8'hC0, "R8 lower nibble padded", int'(pdata), 8'hC0);
        byte_sel = 1'b0;
        cs_n = 1'b1;
        #1;
        chk(pdata_oe == 1'b0, "R9 disabled with cs_n high", int'(pdata_oe), 0);
        chk(pdata == 8'h00, "R9 zero while disabled", int'(pdata), 0);
        cs_n = 1'b0;
        #1;
        chk(pdata_oe == 1'b1, "R9 enabled with cs_n low", int'(pdata_oe), 1);
        chk(pdata == 8'hA5, "R7 upper byte read", int'(pdata), 8'hA5);

        // R6: next start soon after the end
        start_conv(12'h3E1, 1'b1);
        wait_idle();
        repeat (ACQ + 10) @(negedge clk);
        start_conv(12'h7F0, 1'b0);
        wait_idle();

        // R2: too-short request
        repeat (ACQ + 10) @(negedge clk);
        rc_n = 1'b0;
        repeat (LOW - 1) @(negedge clk);
        rc_n = 1'b1;
        expect_quiet(12, "R2 short request ignored");

        // R4 and R10: toggling and data changes during busy
        start_conv(12'h5A3, 1'b0);
        conv_data = 12'hFFF;
        for (int k = 0; k < 2; k++) begin
            rc_n = 1'b0;
            repeat (3) @(negedge clk);
            rc_n = 1'b1;
            repeat (2) @(negedge clk);
        end
        wait_idle();
        expect_quiet(30, "R4 no pending start after busy");
        byte_sel = 1'b1;
        #1;
        chk(pdata == 8'h30, "R10 R8 sampled at start", int'(pdata), 8'h30);
        byte_sel = 1'b0;

        // R5: restart while controls stay low
        repeat (ACQ + 10) @(negedge clk);
        conv_data = 12'h1B4;
        cs_n = 1'b0;
        rc_n = 1'b0;
        exp_q.push_back({1'b0, 12'h1B4});
        while (busy_n) @(negedge clk);
        conv_data = 12'hC3D;
        exp_q.push_back({1'b1, 12'hC3D});
        while (!busy_n) @(negedge clk);
        @(negedge clk);
        chk(busy_n == 1'b0, "R5 restart after one high cycle", int'(busy_n), 0);
        rc_n = 1'b1;
        wait_idle();
        byte_sel = 1'b1;
        #1;
        chk(pdata == 8'hD0, "R5 R8 restart result", int'(pdata), 8'hD0);
        byte_sel = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule